// File: doc/BRIEF.md
# Hint-Gated Temporal Stream Prefetcher

This block learns recurring sequences of cache misses and replays them as prefetch addresses. Every retired miss that arrives while software has opened a hot region is appended to a circular history log. The log fills a small staging group first and writes that group to the ring in one step. The position of each appended address is also placed in a small bucketed index. When a later demand miss finds its address in the index, the block reads the history entries that followed that address and sends them out, oldest first, through a short address queue with a valid/ready handshake. Replay stops when it reaches the last committed history entry.

Software sends start and stop hints to open and close recording, so only the chosen code regions use history and index space. Lookups continue while recording is closed, so streams recorded earlier can still be replayed. To lower index write traffic, each index update is kept only when a free-running LFSR value is below a programmable threshold. The history append does not depend on that decision.

Top module: `spf_stream_prefetcher`

## Requirements
- R1: A hint with `hint_start`=1 turns recording on and a hint with `hint_start`=0 turns it off. The change applies to misses from the next cycle onward. Recording is off after reset, and a miss that arrives while recording is off is neither appended nor indexed.
- R2: Recorded misses take consecutive history positions in arrival order. They become visible to replay only in complete groups of GROUP (default 4) entries. A lookup hit whose stored position is still in the uncommitted group produces no prefetch.
- R3: A demand miss (`miss_pf_hit`=0) that hits in the index replays the history entries after the stored position, in order. Replay ends at the last committed entry.
- R4: The index bucket is the low BKT_W address bits XOR the next BKT_W bits, which is addr[2:0]^addr[5:3] by default. Each bucket has WAYS (default 2) entries. A new address replaces the bucket's least recently used entry. Recording an address that is already present overwrites its stored position and makes it most recently used.
- R5: An index update takes place only when the LFSR value is below `samp_thresh`. A threshold of 0 blocks every update and a threshold of 256 allows every update. The history append happens either way.
- R6: A miss with `miss_pf_hit`=1 is recorded like any other miss but never starts a lookup.
- R7: A new lookup hit discards everything still queued and restarts replay from the new position.
- R8: While `pf_valid`=1 and `pf_ready`=0, `pf_valid` stays high and `pf_addr` does not change.
- R9: Lookups and replay continue while recording is off.
- R10: After reset, `pf_valid` is 0 and the index is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A retired miss is presented |
| miss_addr | input | ADDR_W | Line address of the miss |
| miss_pf_hit | input | 1 | The access hit on prefetched data (record only, no lookup) |
| hint_valid | input | 1 | A software region hint is presented |
| hint_start | input | 1 | 1 opens recording, 0 closes it |
| samp_thresh | input | LFSR_W+1 | Index update sampling threshold |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_addr | output | ADDR_W | Prefetch line address |
| pf_ready | input | 1 | Consumer accepts the offered address |

## Verification
The assertions assume that `pf_ready` is the only backpressure and that a lookup hit may arrive at any time, including while the queue is stalled. They also assume that hints and misses are sampled only on clock edges. The stimulus keeps every lookup to periods when recording is off, keeps the total number of recorded entries below the ring depth so that no stored position is overwritten, and drives sampling only at the thresholds 0 and 256. Under those limits the expected prefetch stream depends only on the order of the recorded misses and the contents of each bucket.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // fold two adjacent bit fields of the address into a bucket number
  function automatic int unsigned spf_fold_hash(input logic [31:0] addr, input int unsigned bw);
    logic [31:0] mask;
    logic [31:0] lo;
    logic [31:0] hi;
    mask = (32'd1 << bw) - 32'd1;
    lo   = addr & mask;
    hi   = (addr >> bw) & mask;
    return int'(lo ^ hi);
  endfunction

  // forward distance on a ring of the given depth
  function automatic int unsigned spf_ring_dist(input int unsigned from_pos,
                                                input int unsigned to_pos,
                                                input int unsigned depth);
    return (to_pos + depth - from_pos) % depth;
  endfunction

endpackage

// File: rtl/spf_history.sv
module spf_history #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 32,
  parameter int GROUP  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       app_en,
  input  logic [ADDR_W-1:0]          app_addr,
  output logic [$clog2(DEPTH)-1:0]   app_pos,
  output logic [$clog2(DEPTH)-1:0]   wptr,
  output logic [$clog2(GROUP+1)-1:0] stage_cnt,
  input  logic [$clog2(DEPTH)-1:0]   rd_ptr,
  output logic [ADDR_W-1:0]          rd_addr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(GROUP+1);

  logic [ADDR_W-1:0] ring  [DEPTH];
  logic [ADDR_W-1:0] stage [GROUP];
  logic              group_done;

  assign group_done = app_en && (stage_cnt == CNT_W'(GROUP-1));
  assign app_pos    = wptr + PTR_W'(stage_cnt);
  assign rd_addr    = ring[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      stage_cnt <= '0;
    end else if (app_en) begin
      if (group_done) begin
        stage_cnt <= '0;
        wptr      <= wptr + PTR_W'(GROUP);
      end else begin
        stage_cnt <= stage_cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (app_en) stage[stage_cnt] <= app_addr;
  end

  always_ff @(posedge clk) begin
    if (group_done) begin
      for (int j = 0; j < GROUP; j++) begin
        if (j == GROUP-1) ring[wptr + PTR_W'(j)] <= app_addr;
        else              ring[wptr + PTR_W'(j)] <= stage[j];
      end
    end
  end

  AST_WPTR_GROUP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr != $past(wptr)) |-> (wptr == $past(wptr) + PTR_W'(GROUP))); // R2
  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stage_cnt < CNT_W'(GROUP)); // R2

endmodule

// File: rtl/spf_index.sv
module spf_index
  import spf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PTR_W   = 5,
  parameter int BUCKETS = 8,
  parameter int WAYS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [PTR_W-1:0]  lk_pos,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [PTR_W-1:0]  upd_pos
);
  localparam int BKT_W = $clog2(BUCKETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int AGE_W = WAY_W;

  logic              vld [BUCKETS][WAYS];
  logic [ADDR_W-1:0] tag [BUCKETS][WAYS];
  logic [PTR_W-1:0]  pos [BUCKETS][WAYS];
  logic [AGE_W-1:0]  age [BUCKETS][WAYS];

  logic [BKT_W-1:0]  lk_b;
  logic [BKT_W-1:0]  ub;
  logic              u_match;
  logic [WAY_W-1:0]  u_hit_way;
  logic [WAY_W-1:0]  u_lru_way;
  logic [WAY_W-1:0]  u_way;
  logic [WAYS-1:0]   lru_vec;

  assign lk_b = BKT_W'(spf_fold_hash(32'(lk_addr), BKT_W));
  assign ub   = BKT_W'(spf_fold_hash(32'(upd_addr), BKT_W));

  always_comb begin
    lk_hit = 1'b0;
    lk_pos = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[lk_b][w] && (tag[lk_b][w] == lk_addr)) begin
        lk_hit = 1'b1;
        lk_pos = pos[lk_b][w];
      end
    end
  end

  always_comb begin
    u_match   = 1'b0;
    u_hit_way = '0;
    u_lru_way = '0;
    lru_vec   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[ub][w] && (tag[ub][w] == upd_addr)) begin
        u_match   = 1'b1;
        u_hit_way = WAY_W'(w);
      end
      if (age[ub][w] == AGE_W'(WAYS-1)) begin
        lru_vec[w] = 1'b1;
        u_lru_way  = WAY_W'(w);
      end
    end
    u_way = u_match ? u_hit_way : u_lru_way;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BUCKETS; b++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld[b][w] <= 1'b0;
          age[b][w] <= AGE_W'(w);
        end
      end
    end else if (upd_en) begin
      vld[ub][u_way] <= 1'b1;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == u_way)               age[ub][w] <= '0;
        else if (age[ub][w] < age[ub][u_way]) age[ub][w] <= age[ub][w] + AGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag[ub][u_way] <= upd_addr;
      pos[ub][u_way] <= upd_pos;
    end
  end

  AST_LRU_SINGLE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ($countones(lru_vec) == 1)); // R4

endmodule

// File: rtl/spf_addr_queue.sv
module spf_addr_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] rdp;
  logic [IW-1:0] wrp;
  logic [CW-1:0] cnt;
  logic          pop;

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rdp];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rdp <= '0;
      wrp <= '0;
      cnt <= '0;
    end else begin
      if (push) wrp <= (wrp == IW'(DEPTH-1)) ? '0 : wrp + IW'(1);
      if (pop)  rdp <= (rdp == IW'(DEPTH-1)) ? '0 : rdp + IW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrp] <= push_data;
  end

  AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data))); // R8

endmodule

// File: rtl/spf_stream_prefetcher.sv
module spf_stream_prefetcher
  import spf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int HIST_DEPTH = 32,
  parameter int GROUP      = 4,
  parameter int BUCKETS    = 8,
  parameter int WAYS       = 2,
  parameter int Q_DEPTH    = 4,
  parameter int LFSR_W     = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_pf_hit,
  input  logic              hint_valid,
  input  logic              hint_start,
  input  logic [LFSR_W:0]   samp_thresh,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_ready
);
  localparam int PTR_W = $clog2(HIST_DEPTH);
  localparam int CNT_W = $clog2(GROUP+1);

  logic              rec_en;
  logic [LFSR_W-1:0] lfsr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              replay_on;

  // named internal events
  logic              demand;
  logic              app_en;
  logic              sample_ok;
  logic              upd_en;
  logic              lk_hit;
  logic [PTR_W-1:0]  lk_pos;
  logic              in_stage;
  logic              start_replay;
  logic              replay_push;
  logic              q_full;
  logic [PTR_W-1:0]  app_pos;
  logic [PTR_W-1:0]  wptr;
  logic [CNT_W-1:0]  stage_cnt;
  logic [ADDR_W-1:0] hist_rd;

  assign demand       = miss_valid && !miss_pf_hit;
  assign app_en       = miss_valid && rec_en;
  assign sample_ok    = {1'b0, lfsr} < samp_thresh;
  assign upd_en       = app_en && sample_ok;
  assign in_stage     = spf_ring_dist(int'(wptr), int'(lk_pos), HIST_DEPTH) < int'(stage_cnt);
  assign start_replay = demand && lk_hit && !in_stage;
  assign replay_push  = replay_on && !start_replay && (rd_ptr != wptr) && !q_full;

  always_ff @(posedge clk) begin
    if (!rst_n)          rec_en <= 1'b0;
    else if (hint_valid) rec_en <= hint_start;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lfsr <= LFSR_W'(1);
    else if (app_en) lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      replay_on <= 1'b0;
      rd_ptr    <= '0;
    end else if (start_replay) begin
      replay_on <= 1'b1;
      rd_ptr    <= lk_pos + PTR_W'(1);
    end else if (replay_on) begin
      if (rd_ptr == wptr)  replay_on <= 1'b0;
      else if (!q_full)    rd_ptr    <= rd_ptr + PTR_W'(1);
    end
  end

  spf_history #(.ADDR_W(ADDR_W), .DEPTH(HIST_DEPTH), .GROUP(GROUP)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .app_en    (app_en),
    .app_addr  (miss_addr),
    .app_pos   (app_pos),
    .wptr      (wptr),
    .stage_cnt (stage_cnt),
    .rd_ptr    (rd_ptr),
    .rd_addr   (hist_rd)
  );

  spf_index #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .BUCKETS(BUCKETS), .WAYS(WAYS)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (miss_addr),
    .lk_hit   (lk_hit),
    .lk_pos   (lk_pos),
    .upd_en   (upd_en),
    .upd_addr (miss_addr),
    .upd_pos  (app_pos)
  );

  spf_addr_queue #(.W(ADDR_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start_replay),
    .push      (replay_push),
    .push_data (hist_rd),
    .full      (q_full),
    .out_valid (pf_valid),
    .out_data  (pf_addr),
    .out_ready (pf_ready)
  );

  AST_NO_RECORD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |=> ($stable(wptr) && $stable(stage_cnt))); // R1
  AST_FLUSH_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_replay |=> !pf_valid); // R7
  AST_PFHIT_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_pf_hit && !replay_on) |=> !replay_on); // R6
  AST_SAMPLE_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_thresh == '0) |-> !upd_en); // R5

endmodule

// File: tb/spf_stream_prefetcher_test.sv
module spf_stream_prefetcher_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [15:0] miss_addr = '0;
  logic        miss_pf_hit = 1'b0;
  logic        hint_valid = 1'b0;
  logic        hint_start = 1'b0;
  logic [8:0]  samp_thresh = 9'd256;
  logic        pf_valid;
  logic [15:0] pf_addr;
  logic        pf_ready = 1'b0;

  spf_stream_prefetcher uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_pf_hit(miss_pf_hit), .hint_valid(hint_valid), .hint_start(hint_start),
    .samp_thresh(samp_thresh), .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0;
  int          fails  = 0;
  string       cur_req = "R3";
  int          rdy_mode = 1;
  bit          tog = 1'b0;
  bit          rdy_now;
  logic [15:0] exp_q[$];
  logic [15:0] popped;

  // reference model
  logic [15:0] hist_m[$];
  bit          rec_m = 1'b0;
  int          thr_m = 256;
  logic [15:0] ma [8][2];
  int          mp [8][2];
  bit          mv [8][2];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int bkt(input logic [15:0] a);
    int v;
    v = int'(a);
    return (v % 8) ^ ((v / 8) % 8);
  endfunction

  task automatic model_find(input logic [15:0] a, output bit hit, output int p);
    int b;
    b = bkt(a);
    hit = 1'b0;
    p = 0;
    for (int s = 0; s < 2; s++) if (mv[b][s] && ma[b][s] == a) begin hit = 1'b1; p = mp[b][s]; end
  endtask

  // slot 0 is most recently used
  task automatic model_update(input logic [15:0] a, input int p);
    int b;
    b = bkt(a);
    if (mv[b][0] && ma[b][0] == a) begin
      mp[b][0] = p;
    end else begin
      ma[b][1] = ma[b][0]; mp[b][1] = mp[b][0]; mv[b][1] = mv[b][0];
      ma[b][0] = a;        mp[b][0] = p;        mv[b][0] = 1'b1;
    end
  endtask

  task automatic do_miss(input logic [15:0] a, input bit pfh);
    bit hit;
    int p;
    int committed;
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a; miss_pf_hit = pfh;
    hit = 1'b0;
    p = 0;
    if (!pfh) model_find(a, hit, p);
    if (rec_m) begin
      hist_m.push_back(a);
      if (thr_m != 0) model_update(a, hist_m.size() - 1);
    end
    if (hit) begin
      committed = (hist_m.size() / 4) * 4;
      if (p < committed) begin
        exp_q.delete();
        for (int k = p + 1; k < committed; k++) exp_q.push_back(hist_m[k]);
      end
    end
    @(negedge clk);
    miss_valid = 1'b0; miss_pf_hit = 1'b0;
  endtask

  task automatic do_hint(input bit st);
    @(negedge clk);
    hint_valid = 1'b1; hint_start = st;
    @(negedge clk);
    hint_valid = 1'b0;
    rec_m = st;
  endtask

  task automatic settle(input string req);
    repeat (80) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(pf_valid == 1'b0, req, pf_valid, 0);
  endtask

  // monitor: choose ready for the coming edge, pop the item that edge accepts
  always @(negedge clk) begin
    if (rst_n) begin
      tog = ~tog;
      rdy_now = (rdy_mode == 1) || (rdy_mode == 2 && tog);
      pf_ready = rdy_now;
      if (pf_valid && rdy_now) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, pf_addr, 32'hFFFF_FFFF);
        end else begin
          popped = exp_q.pop_front();
          check(pf_addr == popped, cur_req, pf_addr, popped);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) for (int s = 0; s < 2; s++) mv[b][s] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pf_valid == 1'b0, "R10", pf_valid, 0);

    // R1: not recorded while recording is off
    cur_req = "R1";
    do_miss(16'h4001, 1'b0);
    settle("R10");

    // record X0..X9 (buckets 0..7,0,1)
    do_hint(1'b1);
    for (int i = 0; i < 10; i++) do_miss(16'h1000 + 16'(i * 8), 1'b0);
    do_hint(1'b0);

    // R3 / R9: replay X3..X7 with recording off, stop at commit
    cur_req = "R3";
    do_miss(16'h1010, 1'b0);
    check(exp_q.size() == 5, "R3", exp_q.size(), 5);
    settle("R3");

    // R2: hit on a staged entry yields nothing
    cur_req = "R2";
    do_miss(16'h1040, 1'b0);
    settle("R2");

    // R1 / R9: misses while off are not appended
    cur_req = "R1";
    do_miss(16'h4002, 1'b0);
    do_miss(16'h4001, 1'b0);
    settle("R1");
    cur_req = "R9";
    do_miss(16'h1010, 1'b0);
    check(exp_q.size() == 5, "R9", exp_q.size(), 5);
    settle("R9");

    // R8: alternating backpressure, full stream X1..X7
    cur_req = "R8";
    rdy_mode = 2;
    do_miss(16'h1000, 1'b0);
    settle("R8");

    // R7 / R8: hold, then flush with a new hit
    rdy_mode = 0;
    cur_req = "R7";
    do_miss(16'h1000, 1'b0);
    repeat (10) @(negedge clk);
    check(pf_valid == 1'b1 && pf_addr == 16'h1008, "R8", pf_addr, 16'h1008);
    repeat (3) @(negedge clk);
    check(pf_valid == 1'b1 && pf_addr == 16'h1008, "R8", pf_addr, 16'h1008);
    do_miss(16'h1028, 1'b0);
    check(exp_q.size() == 2, "R7", exp_q.size(), 2);
    rdy_mode = 1;
    settle("R7");

    // R6: prefetched-data hit is recorded but starts no lookup
    cur_req = "R6";
    do_hint(1'b1);
    do_miss(16'h1000, 1'b1);
    do_miss(16'h5003, 1'b0);
    do_hint(1'b0);
    settle("R6");
    do_miss(16'h1018, 1'b0);
    check(exp_q.size() == 8, "R6", exp_q.size(), 8);
    settle("R6");

    // R5: threshold 0 appends history but leaves the index untouched
    cur_req = "R5";
    samp_thresh = 9'd0;
    thr_m = 0;
    do_hint(1'b1);
    for (int i = 0; i < 4; i++) do_miss(16'h6010 + 16'(i), 1'b0);
    do_hint(1'b0);
    do_miss(16'h6011, 1'b0);
    settle("R5");
    do_miss(16'h1018, 1'b0);
    check(exp_q.size() == 12, "R5", exp_q.size(), 12);
    settle("R5");

    // R4: two new addresses in bucket 5 evict X5 (least recently used)
    cur_req = "R4";
    samp_thresh = 9'd256;
    thr_m = 256;
    do_hint(1'b1);
    do_miss(16'h2005, 1'b0);
    do_miss(16'h2028, 1'b0);
    do_miss(16'h3006, 1'b0);
    do_miss(16'h3007, 1'b0);
    do_hint(1'b0);
    do_miss(16'h1028, 1'b0);
    settle("R4");
    do_miss(16'h2005, 1'b0);
    check(exp_q.size() == 3, "R4", exp_q.size(), 3);
    settle("R4");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule